// File: doc/BRIEF.md
# Staged Fault Trigger Sequencer

This block watches a target processor's bus one bus cycle at a time and decides the exact cycle in which a pin-level fault starts and the cycle in which it ends. A run passes through a fixed chain of stages. First it counts bus cycles whose address equals a programmed activation address. Next it waits a programmed number of further bus cycles. An optional qualifier then waits for a programmed bit pattern, with a per-bit care mask. Last, it holds a fault-enable for a programmed number of bus cycles and presents a wide line-select mask alongside it. The same settings always give the same injection point, including a point deep inside a program loop.

A host loads the settings through a simple write port: a select code, a data word and a write enable. A one-cycle arm pulse starts a run. Each arm yields exactly one injection. After that a done flag stays high until the next arm. The bus-cycle strobe works as a valid signal with no ready, because a bus monitor cannot stall the bus. Address and pattern lines are looked at only in cycles where the strobe is high, and every such cycle is consumed. There is no back-pressure in either direction.

Top module: `fault_trig_seq`

## Requirements
- R1: After reset the sequencer is idle. fault_en and done are low and fault_mask is all zeros. Strobes carrying the activation address and pattern cause no injection until an arm pulse.
- R2: The address stage counts strobe cycles in which bus_addr equals the activation address (select 0, low ADDR_W bits of the data word). The stage ends on the C-th such cycle, where C is the count setting (select 1, bits [7:0]). C = 0 behaves like C = 1.
- R3: After the address stage, the sequencer waits D further strobe cycles, where D is the delay setting (select 2, bits [15:0]). With D = 0 the next stage is active from the very next cycle.
- R4: The pattern setting (select 3) holds the value in bits [15:0] and the care mask in bits [31:16]. A strobe cycle qualifies when bus_pat equals the value on every bit whose care bit is 1. Bits whose care bit is 0 are ignored.
- R5: The placement setting (select 5, bits [1:0]) places the qualifier. 0 skips it. 1 places it after the delay. 2 places it between the address stage and the delay. 3 behaves like 0.
- R6: fault_en rises in the cycle after the strobe that completes the last stage before injection. It stays high until N more strobe cycles have been seen, where N is the duration setting (select 4, bits [7:0]) and N = 0 behaves like N = 1. It falls in the cycle after the N-th of those strobes.
- R7: Select 6+k holds mask bits [32k+31:32k]. fault_mask equals the programmed mask whenever fault_en is high and is all zeros otherwise.
- R8: Only cycles with bus_stb high advance any count or test the pattern. Address and pattern values in cycles without a strobe have no effect.
- R9: An arm pulse clears all counts and restarts at the address stage. It wins over a strobe in the same cycle, which is not counted, and an arm during injection ends the injection in the next cycle. After an injection, done is high and no further injection happens until the next arm, which clears done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Setting write enable |
| cfg_sel | input | 4 | Setting select code |
| cfg_wdata | input | 32 | Setting write data |
| arm | input | 1 | One-cycle start of a run |
| bus_stb | input | 1 | Bus-cycle strobe (valid, never stalled) |
| bus_addr | input | ADDR_W | Observed bus address |
| bus_pat | input | PAT_W | Observed qualifier lines |
| fault_en | output | 1 | Fault active |
| fault_mask | output | MASK_W | Lines to fault, zero when inactive |
| done | output | 1 | Injection finished for this arm |

## Verification
The collision that matters most is an arm pulse landing in the same cycle as a strobe that carries the activation address. The bench provokes it mid-count and judges the outcome by how many further matching strobes are needed before fault_en rises: only the strobes after the arm may count. It also lands an arm on a strobe during injection and expects fault_en and done both low in the next cycle. The delay-boundary case, where the final delay strobe coincides with a qualifying pattern, is swept by placement mode and judged by the arithmetic rule that the pattern is tested only from the following strobe onward.

// File: rtl/fts_pkg.sv
package fts_pkg;
  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_DLY  = 3'd2,
    ST_PAT  = 3'd3,
    ST_INJ  = 3'd4,
    ST_DONE = 3'd5
  } fts_state_e;

  localparam logic [1:0] QM_POST = 2'd1;
  localparam logic [1:0] QM_PRE  = 2'd2;

  localparam logic [3:0] SEL_ADDR  = 4'd0;
  localparam logic [3:0] SEL_CNT   = 4'd1;
  localparam logic [3:0] SEL_DLY   = 4'd2;
  localparam logic [3:0] SEL_PAT   = 4'd3;
  localparam logic [3:0] SEL_DUR   = 4'd4;
  localparam logic [3:0] SEL_MODE  = 4'd5;
  localparam logic [3:0] SEL_MASK0 = 4'd6;
endpackage

// File: rtl/fts_cfg_regs.sv
module fts_cfg_regs
  import fts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAT_W  = 16,
  parameter int MASK_W = 96,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 16,
  parameter int DUR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  output logic [ADDR_W-1:0] act_addr,
  output logic [CNT_W-1:0]  act_cnt,
  output logic [DLY_W-1:0]  dly_len,
  output logic [PAT_W-1:0]  pat_val,
  output logic [PAT_W-1:0]  pat_care,
  output logic [DUR_W-1:0]  dur_len,
  output logic [1:0]        qmode,
  output logic [MASK_W-1:0] mask
);
  localparam int MW = (MASK_W + 31) / 32;

  logic [32*MW-1:0] mask_flat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_addr <= '0;
      act_cnt  <= '0;
      dly_len  <= '0;
      pat_val  <= '0;
      pat_care <= '0;
      dur_len  <= '0;
      qmode    <= '0;
    end else if (cfg_we) begin
      case (cfg_sel)
        SEL_ADDR: act_addr <= cfg_wdata[ADDR_W-1:0];
        SEL_CNT:  act_cnt  <= cfg_wdata[CNT_W-1:0];
        SEL_DLY:  dly_len  <= cfg_wdata[DLY_W-1:0];
        SEL_PAT: begin
          pat_val  <= cfg_wdata[PAT_W-1:0];
          pat_care <= cfg_wdata[16 +: PAT_W];
        end
        SEL_DUR:  dur_len  <= cfg_wdata[DUR_W-1:0];
        SEL_MODE: qmode    <= cfg_wdata[1:0];
        default: ;
      endcase
    end
  end

  for (genvar k = 0; k < MW; k++) begin : g_mword
    logic [31:0] word_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        word_q <= '0;
      else if (cfg_we && cfg_sel == (SEL_MASK0 + 4'(k)))
        word_q <= cfg_wdata;
    end
    assign mask_flat[32*k +: 32] = word_q;
  end

  assign mask = mask_flat[MASK_W-1:0];
endmodule

// File: rtl/fts_match.sv
module fts_match #(
  parameter int ADDR_W = 32,
  parameter int PAT_W  = 16
) (
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [ADDR_W-1:0] act_addr,
  input  logic [PAT_W-1:0]  bus_pat,
  input  logic [PAT_W-1:0]  pat_val,
  input  logic [PAT_W-1:0]  pat_care,
  output logic              addr_hit,
  output logic              pat_hit
);
  logic [PAT_W-1:0] diff;

  always_comb begin
    addr_hit = (bus_addr == act_addr);
    diff     = (bus_pat ^ pat_val) & pat_care;
    pat_hit  = (diff == '0);
  end
endmodule

// File: rtl/fts_stage_cnt.sv
module fts_stage_cnt #(
  parameter int W           = 8,
  parameter bit ZERO_IS_ONE = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         step,
  input  logic [W-1:0] target,
  output logic         last
);
  logic [W-1:0] cnt;
  logic [W:0]   goal;
  logic [W:0]   nxt;

  if (ZERO_IS_ONE) begin : g_zero_one
    assign goal = (target == '0) ? (W+1)'(1) : {1'b0, target};
  end else begin : g_plain
    assign goal = {1'b0, target};
  end

  assign nxt  = {1'b0, cnt} + (W+1)'(1);
  assign last = step && (nxt >= goal);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt <= '0;
    else if (clr)
      cnt <= '0;
    else if (step)
      cnt <= nxt[W-1:0];
  end

  // R8: a count moves only on a qualified step or a clear
  a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr && !step) |=> $stable(cnt));
endmodule

// File: rtl/fts_seq_fsm.sv
module fts_seq_fsm
  import fts_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       arm,
  input  logic       bus_stb,
  input  logic       addr_hit,
  input  logic       pat_hit,
  input  logic       dly_zero,
  input  logic [1:0] qmode,
  input  logic       addr_last,
  input  logic       dly_last,
  input  logic       inj_last,
  output logic       addr_step,
  output logic       dly_step,
  output logic       inj_step,
  output logic       addr_clr,
  output logic       dly_clr,
  output logic       inj_clr,
  output logic       fault_en,
  output logic       done
);
  fts_state_e state, nxt, after_addr, after_dly, after_pat;
  logic       qual_post, qual_pre;

  always_comb begin
    qual_post  = (qmode == QM_POST);
    qual_pre   = (qmode == QM_PRE);
    after_dly  = qual_post ? ST_PAT : ST_INJ;
    after_addr = qual_pre ? ST_PAT : (dly_zero ? after_dly : ST_DLY);
    after_pat  = (qual_pre && !dly_zero) ? ST_DLY : ST_INJ;

    nxt = state;
    case (state)
      ST_IDLE: nxt = ST_IDLE;
      ST_ADDR: if (addr_last) nxt = after_addr;
      ST_DLY:  if (dly_last) nxt = after_dly;
      ST_PAT:  if (bus_stb && pat_hit) nxt = after_pat;
      ST_INJ:  if (inj_last) nxt = ST_DONE;
      ST_DONE: nxt = ST_DONE;
      default: nxt = ST_IDLE;
    endcase
    if (arm) nxt = ST_ADDR;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end

  always_comb begin
    addr_step = (state == ST_ADDR) && bus_stb && addr_hit;
    dly_step  = (state == ST_DLY) && bus_stb;
    inj_step  = (state == ST_INJ) && bus_stb;
    addr_clr  = arm || (state != ST_ADDR);
    dly_clr   = arm || (state != ST_DLY);
    inj_clr   = arm || (state != ST_INJ);
    fault_en  = (state == ST_INJ);
    done      = (state == ST_DONE);
  end

  // R8: without a strobe or arm the stage never changes
  a_r8_hold_no_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_stb && !arm) |=> $stable(state));
  // R9: arm always restarts at the address stage
  a_r9_arm_restart: assert property (@(posedge clk) disable iff (!rst_n)
    arm |=> (state == ST_ADDR));
  // R9: done persists until the next arm
  a_r9_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !arm) |=> done);
  // R6: injection only starts after a bus-cycle strobe
  a_r6_rise_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault_en) |-> $past(bus_stb));
endmodule

// File: rtl/fault_trig_seq.sv
module fault_trig_seq
  import fts_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAT_W  = 16,
  parameter int MASK_W = 96,
  parameter int CNT_W  = 8,
  parameter int DLY_W  = 16,
  parameter int DUR_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [3:0]        cfg_sel,
  input  logic [31:0]       cfg_wdata,
  input  logic              arm,
  input  logic              bus_stb,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [PAT_W-1:0]  bus_pat,
  output logic              fault_en,
  output logic [MASK_W-1:0] fault_mask,
  output logic              done
);
  logic [ADDR_W-1:0] act_addr;
  logic [CNT_W-1:0]  act_cnt;
  logic [DLY_W-1:0]  dly_len;
  logic [PAT_W-1:0]  pat_val, pat_care;
  logic [DUR_W-1:0]  dur_len;
  logic [1:0]        qmode;
  logic [MASK_W-1:0] mask;
  logic addr_hit, pat_hit;
  logic addr_step, dly_step, inj_step;
  logic addr_clr, dly_clr, inj_clr;
  logic addr_last, dly_last, inj_last;

  fts_cfg_regs #(
    .ADDR_W(ADDR_W), .PAT_W(PAT_W), .MASK_W(MASK_W),
    .CNT_W(CNT_W), .DLY_W(DLY_W), .DUR_W(DUR_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .act_addr(act_addr), .act_cnt(act_cnt),
    .dly_len(dly_len), .pat_val(pat_val), .pat_care(pat_care),
    .dur_len(dur_len), .qmode(qmode), .mask(mask)
  );

  fts_match #(.ADDR_W(ADDR_W), .PAT_W(PAT_W)) u_match (
    .bus_addr(bus_addr), .act_addr(act_addr), .bus_pat(bus_pat),
    .pat_val(pat_val), .pat_care(pat_care),
    .addr_hit(addr_hit), .pat_hit(pat_hit)
  );

  fts_stage_cnt #(.W(CNT_W), .ZERO_IS_ONE(1'b1)) u_addr_cnt (
    .clk(clk), .rst_n(rst_n), .clr(addr_clr), .step(addr_step),
    .target(act_cnt), .last(addr_last)
  );

  fts_stage_cnt #(.W(DLY_W), .ZERO_IS_ONE(1'b0)) u_dly_cnt (
    .clk(clk), .rst_n(rst_n), .clr(dly_clr), .step(dly_step),
    .target(dly_len), .last(dly_last)
  );

  fts_stage_cnt #(.W(DUR_W), .ZERO_IS_ONE(1'b1)) u_inj_cnt (
    .clk(clk), .rst_n(rst_n), .clr(inj_clr), .step(inj_step),
    .target(dur_len), .last(inj_last)
  );

  fts_seq_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .arm(arm), .bus_stb(bus_stb),
    .addr_hit(addr_hit), .pat_hit(pat_hit), .dly_zero(dly_len == '0),
    .qmode(qmode), .addr_last(addr_last), .dly_last(dly_last),
    .inj_last(inj_last), .addr_step(addr_step), .dly_step(dly_step),
    .inj_step(inj_step), .addr_clr(addr_clr), .dly_clr(dly_clr),
    .inj_clr(inj_clr), .fault_en(fault_en), .done(done)
  );

  assign fault_mask = fault_en ? mask : '0;

  // R7: mask output is silent whenever the sequencer has finished
  a_r7_mask_quiet_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fault_mask == '0));
endmodule

// File: tb/tb_fault_trig_seq.sv
module tb_fault_trig_seq;
  localparam logic [31:0] TA   = 32'h0000_1F40;
  localparam logic [15:0] PV   = 16'hA5C3;
  localparam logic [15:0] CARE = 16'hFF0F;
  localparam logic [95:0] MEXP = {32'h8000_0001, 32'h0123_4567, 32'hDEAD_BEEF};

  logic        clk = 1'b0;
  logic        rst_n, cfg_we, arm, bus_stb;
  logic [3:0]  cfg_sel;
  logic [31:0] cfg_wdata, bus_addr;
  logic [15:0] bus_pat;
  logic        fault_en, done;
  logic [95:0] fault_mask;
  int errs = 0;
  int checks = 0;

  fault_trig_seq dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .arm(arm), .bus_stb(bus_stb),
    .bus_addr(bus_addr), .bus_pat(bus_pat), .fault_en(fault_en),
    .fault_mask(fault_mask), .done(done)
  );

  always #10 clk = ~clk;

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog R9 actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  task automatic chk(input string tag, input logic [95:0] act, input logic [95:0] exp);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cfg_write(input logic [3:0] sel, input logic [31:0] d);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = d; bus_stb = 1'b0;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic arm_pulse();
    arm = 1'b1; bus_stb = 1'b0;
    tick();
    arm = 1'b0;
  endtask

  task automatic stb_cyc(input logic s, input logic [31:0] a);
    bus_stb = s; bus_addr = a;
    tick();
    bus_stb = 1'b0;
  endtask

  // Address matches on strobe j when j%3 != 1; pattern qualifies when j%4 == 3
  task automatic run_case(input int cnt, input int dly, input int dur,
                          input int mode, input int gap);
    int need, seen, ka, s, nd, t, j, m;
    logic st;
    cfg_write(4'd1, 32'(cnt));
    cfg_write(4'd2, 32'(dly));
    cfg_write(4'd4, 32'(dur));
    cfg_write(4'd5, 32'(mode));
    arm_pulse();
    need = (cnt == 0) ? 1 : cnt;
    seen = 0; ka = 0;
    for (int k = 0; seen < need; k++)
      if (k % 3 != 1) begin seen++; ka = k; end
    if (mode == 1) begin
      s = ka + dly + 1;
      while (s % 4 != 3) s++;
    end else if (mode == 2) begin
      m = ka + 1;
      while (m % 4 != 3) m++;
      s = m + dly;
    end else begin
      s = ka + dly;
    end
    nd = (dur == 0) ? 1 : dur;
    t = -1;
    for (int c = 0; t < s + nd + 2; c++) begin
      st = (gap != 0) ? (c % 3 != 2) : 1'b1;
      j = t + 1;
      if (st) begin
        bus_addr = (j % 3 != 1) ? TA : TA + 32'd4;
        bus_pat  = (j % 4 == 3) ? (PV ^ 16'h00F0) : (PV ^ 16'h0100);
      end else begin
        bus_addr = TA;
        bus_pat  = PV;
      end
      bus_stb = st;
      tick();
      if (st) t++;
      chk("R2 R3 R4 R5 R6 R8 enable", {95'd0, fault_en}, {95'd0, (t >= s) && (t < s + nd)});
      chk("R9 done", {95'd0, done}, {95'd0, t >= s + nd});
      chk("R7 mask", fault_mask, ((t >= s) && (t < s + nd)) ? MEXP : 96'd0);
    end
    bus_stb = 1'b0;
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_sel = '0; cfg_wdata = '0;
    arm = 1'b0; bus_stb = 1'b0; bus_addr = '0; bus_pat = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    tick();
    chk("R1 enable", {95'd0, fault_en}, 96'd0);
    chk("R1 mask", fault_mask, 96'd0);
    chk("R1 done", {95'd0, done}, 96'd0);

    cfg_write(4'd0, TA);
    cfg_write(4'd3, {CARE, PV});
    cfg_write(4'd6, MEXP[31:0]);
    cfg_write(4'd7, MEXP[63:32]);
    cfg_write(4'd8, MEXP[95:64]);
    cfg_write(4'd1, 32'd1);
    bus_pat = PV;
    for (int i = 0; i < 6; i++) begin
      stb_cyc(1'b1, TA);
      chk("R1 no arm enable", {95'd0, fault_en}, 96'd0);
      chk("R1 no arm done", {95'd0, done}, 96'd0);
    end

    for (int md = 0; md < 4; md++)
      for (int g = 0; g < 2; g++)
        for (int cn = 0; cn < 4; cn++)
          for (int dl = 0; dl < 4; dl++)
            for (int du = 0; du < 3; du++)
              run_case(cn, (dl == 3) ? 5 : dl, (du == 2) ? 3 : du, md, g);

    run_case(255, 1000, 255, 1, 0);
    run_case(200, 0, 7, 2, 1);

    // R9 collisions: arm on a counted strobe, arm during injection, one shot per arm
    cfg_write(4'd1, 32'd2);
    cfg_write(4'd2, 32'd0);
    cfg_write(4'd4, 32'd2);
    cfg_write(4'd5, 32'd0);
    arm_pulse();
    stb_cyc(1'b1, TA);
    chk("R2 first of two", {95'd0, fault_en}, 96'd0);
    arm = 1'b1;
    stb_cyc(1'b1, TA);
    arm = 1'b0;
    chk("R9 arm with strobe", {95'd0, fault_en}, 96'd0);
    stb_cyc(1'b1, TA);
    chk("R9 strobe at arm not counted", {95'd0, fault_en}, 96'd0);
    stb_cyc(1'b1, TA);
    chk("R9 second count after arm", {95'd0, fault_en}, 96'd1);
    stb_cyc(1'b1, TA + 32'd8);
    chk("R6 still active", {95'd0, fault_en}, 96'd1);
    arm = 1'b1;
    stb_cyc(1'b1, TA);
    arm = 1'b0;
    chk("R9 arm ends injection", {95'd0, fault_en}, 96'd0);
    chk("R9 arm ends injection done", {95'd0, done}, 96'd0);
    stb_cyc(1'b1, TA);
    stb_cyc(1'b1, TA);
    chk("R9 rerun active", {95'd0, fault_en}, 96'd1);
    stb_cyc(1'b1, TA);
    stb_cyc(1'b1, TA);
    chk("R9 rerun done", {95'd0, done}, 96'd1);
    for (int i = 0; i < 6; i++) begin
      stb_cyc(1'b1, TA);
      chk("R9 single shot enable", {95'd0, fault_en}, 96'd0);
      chk("R9 single shot done", {95'd0, done}, 96'd1);
    end
    arm_pulse();
    chk("R9 arm clears done", {95'd0, done}, 96'd0);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule